// File: doc/BRIEF.md
# Subroutine frame sequencer

This block runs the memory side of subroutine entry and exit for a 32-bit core. It holds the frame-pointer and stack-pointer registers. When it is started with an operation kind, it issues the word accesses that build or tear down a stack frame, then hands a new program counter back to the fetch logic.

A call first reserves a two-word slot below the stack pointer. The return address goes into the lower word of that slot, and the upper word is left for a static-chain value. The caller's frame pointer is then saved one word further down, and both pointers move to that save location. A return uses the frame pointer, not the stack pointer, to find the saved words. It restores the old frame pointer, picks up the return address, and leaves the stack pointer just above the released slot.

Decode happens upstream. For a register call, the value of the register named by the opcode arrives on `target_i`.

Top module: `frame_seq`

## Requirements
- R1: After reset, `sp_o` equals `SP_INIT`, `fp_o` equals `FP_INIT`, and `busy_o`, `done_o`, `fault_o`, `pc_load_o` and `mem_req_o` are all low.
- R2: `op_i` encodes the operation kind as 0 for an absolute call, 1 for a register call, 2 for a return and 3 for reserved. On an absolute call the block makes two writes, in this order: first PC+6 to address SP−8, then the old frame pointer to address SP−12.
- R3: A register call does the same two writes, except that the return address is PC+2.
- R4: When a call completes, `sp_o` and `fp_o` both equal the old SP−12. At the same time, `pc_o` equals the `target_i` value captured with the start, and `pc_load_o` is high in the cycle that `done_o` is high.
- R5: A return reads address FP first and then address FP+4. The new frame pointer is the word read at FP, `pc_o` is the word read at FP+4, and `sp_o` is the old FP+12. `pc_load_o` rises together with `done_o`.
- R6: Each access keeps `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` unchanged until `mem_ready_i` is high. An access with L wait cycles takes L+1 cycles, so a two-access operation raises `done_o` 2L+3 cycles after the start edge.
- R7: `busy_o` is high from the cycle after an accepted start up to and including the single `done_o` cycle. A start seen while busy has no effect, and no memory request is made while the block is idle.
- R8: If a call starts with SP not word aligned, or a return starts with FP not word aligned, the block makes no memory access. `fault_o` and `done_o` are high for one cycle, `sp_o` and `fp_o` keep their values, and `pc_load_o` stays low.
- R9: A start with the reserved operation kind 3 ends in the same way as a fault under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| op_i | input | 2 | Operation kind: 0 absolute call, 1 register call, 2 return, 3 reserved |
| pc_i | input | 32 | Address of the current instruction |
| target_i | input | 32 | Call destination (extension word or register value) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Sequence aborted; high together with done_o |
| pc_load_o | output | 1 | New program counter is valid on pc_o |
| pc_o | output | 32 | Program counter to load |
| fp_o | output | 32 | Frame-pointer register |
| sp_o | output | 32 | Stack-pointer register |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Access accepted this cycle |

## Verification
Nested calls of both kinds are followed by returns that unwind them. Tracing each unwind back to its matching call shows whether the frame pointer, and not the stack pointer, drives the return addresses. Using different return-address offsets for the two call kinds, at different memory wait lengths, separates the PC+6 and PC+2 paths and checks the exact cycle count per access. Putting a misaligned frame pointer into a saved frame, issuing a reserved kind, and asserting start while busy show that the aborted or ignored cases touch neither memory nor the pointer registers.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [1:0] {
    OP_CALL_ABS = 2'd0,
    OP_CALL_REG = 2'd1,
    OP_RET      = 2'd2,
    OP_RSVD     = 2'd3
  } frame_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_RA = 3'd1,
    ST_PUSH_FP = 3'd2,
    ST_POP_FP  = 3'd3,
    ST_POP_PC  = 3'd4,
    ST_END     = 3'd5
  } frame_st_e;
endpackage

// File: rtl/frame_addr_gen.sv
module frame_addr_gen
  import frame_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  frame_st_e        st_i,
  input  logic [DW-1:0]    sp_i,
  input  logic [DW-1:0]    fp_i,
  output logic [DW-1:0]    addr_o,
  output logic             sp_ok_o,
  output logic             fp_ok_o
);
  localparam int WB = DW / 8;
  localparam int AB = $clog2(WB);
  localparam logic [DW-1:0] OFF_SLOT = DW'(2 * WB);
  localparam logic [DW-1:0] OFF_SAVE = DW'(3 * WB);
  localparam logic [DW-1:0] OFF_WORD = DW'(WB);

  // addresses come from committed pointers; they move only at the last beat
  always_comb begin
    unique case (st_i)
      ST_PUSH_RA: addr_o = sp_i - OFF_SLOT;
      ST_PUSH_FP: addr_o = sp_i - OFF_SAVE;
      ST_POP_FP:  addr_o = fp_i;
      ST_POP_PC:  addr_o = fp_i + OFF_WORD;
      default:    addr_o = sp_i;
    endcase
  end

  assign sp_ok_o = ~|sp_i[AB-1:0];
  assign fp_ok_o = ~|fp_i[AB-1:0];
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  frame_op_e  op_i,
  input  logic       ready_i,
  input  logic       sp_ok_i,
  input  logic       fp_ok_i,
  output frame_st_e  st_o,
  output logic       accept_o,
  output logic       req_o,
  output logic       we_o,
  output logic       step_o,
  output logic       done_o,
  output logic       fault_o
);
  frame_st_e st_q, st_d;
  logic      flt_q, flt_d;

  assign accept_o = start_i && (st_q == ST_IDLE);
  assign req_o    = (st_q == ST_PUSH_RA) || (st_q == ST_PUSH_FP) ||
                    (st_q == ST_POP_FP)  || (st_q == ST_POP_PC);
  assign we_o     = (st_q == ST_PUSH_RA) || (st_q == ST_PUSH_FP);
  assign step_o   = req_o && ready_i;
  assign done_o   = (st_q == ST_END);
  assign fault_o  = done_o && flt_q;
  assign st_o     = st_q;

  always_comb begin
    st_d  = st_q;
    flt_d = flt_q;
    unique case (st_q)
      ST_IDLE: begin
        flt_d = 1'b0;
        if (start_i) begin
          unique case (op_i)
            OP_CALL_ABS, OP_CALL_REG: begin
              if (sp_ok_i) st_d = ST_PUSH_RA;
              else begin st_d = ST_END; flt_d = 1'b1; end
            end
            OP_RET: begin
              if (fp_ok_i) st_d = ST_POP_FP;
              else begin st_d = ST_END; flt_d = 1'b1; end
            end
            default: begin st_d = ST_END; flt_d = 1'b1; end
          endcase
        end
      end
      ST_PUSH_RA: if (ready_i) st_d = ST_PUSH_FP;
      ST_PUSH_FP: if (ready_i) st_d = ST_END;
      ST_POP_FP:  if (ready_i) st_d = ST_POP_PC;
      ST_POP_PC:  if (ready_i) st_d = ST_END;
      default: begin st_d = ST_IDLE; flt_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      flt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      flt_q <= flt_d;
    end
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int          DW         = 32,
  parameter logic [31:0] SP_INIT    = 32'h0000_0400,
  parameter logic [31:0] FP_INIT    = 32'h0000_0400,
  parameter int          RA_ABS_OFF = 6,
  parameter int          RA_REG_OFF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] pc_i,
  input  logic [DW-1:0] target_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o,
  output logic          pc_load_o,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] fp_o,
  output logic [DW-1:0] sp_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i
);
  localparam int WB = DW / 8;
  localparam logic [DW-1:0] FRAME_BYTES = DW'(3 * WB);

  frame_st_e     st;
  logic          accept, step, sp_ok, fp_ok;
  logic [DW-1:0] sp_q, fp_q, pc_q, ra_q, tgt_q, nfp_q;
  logic          pc_load_q;
  frame_op_e     op;

  assign op = frame_op_e'(op_i);

  frame_addr_gen #(.DW(DW)) u_addr (
    .st_i   (st),
    .sp_i   (sp_q),
    .fp_i   (fp_q),
    .addr_o (mem_addr_o),
    .sp_ok_o(sp_ok),
    .fp_ok_o(fp_ok)
  );

  frame_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op),
    .ready_i (mem_ready_i),
    .sp_ok_i (sp_ok),
    .fp_ok_i (fp_ok),
    .st_o    (st),
    .accept_o(accept),
    .req_o   (mem_req_o),
    .we_o    (mem_we_o),
    .step_o  (step),
    .done_o  (done_o),
    .fault_o (fault_o)
  );

  always_comb begin
    unique case (st)
      ST_PUSH_RA: mem_wdata_o = ra_q;
      ST_PUSH_FP: mem_wdata_o = fp_q;
      default:    mem_wdata_o = '0;
    endcase
  end

  // operands captured at accept; pointers commit only on the final beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ra_q  <= '0;
      tgt_q <= '0;
      nfp_q <= '0;
    end else begin
      if (accept) begin
        ra_q  <= pc_i + ((op == OP_CALL_ABS) ? DW'(RA_ABS_OFF) : DW'(RA_REG_OFF));
        tgt_q <= target_i;
      end
      if (step && st == ST_POP_FP) nfp_q <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q      <= DW'(SP_INIT);
      fp_q      <= DW'(FP_INIT);
      pc_q      <= '0;
      pc_load_q <= 1'b0;
    end else begin
      pc_load_q <= 1'b0;
      if (step && st == ST_PUSH_FP) begin
        sp_q      <= sp_q - FRAME_BYTES;
        fp_q      <= sp_q - FRAME_BYTES;
        pc_q      <= tgt_q;
        pc_load_q <= 1'b1;
      end else if (step && st == ST_POP_PC) begin
        sp_q      <= fp_q + FRAME_BYTES;
        fp_q      <= nfp_q;
        pc_q      <= mem_rdata_i;
        pc_load_q <= 1'b1;
      end
    end
  end

  assign busy_o    = (st != ST_IDLE);
  assign pc_load_o = pc_load_q;
  assign pc_o      = pc_q;
  assign sp_o      = sp_q;
  assign fp_o      = fp_q;
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o,
  input logic          pc_load_o,
  input logic [DW-1:0] fp_o,
  input logic [DW-1:0] sp_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i
);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !done_o);

  assert_fault_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o && !pc_load_o);

  assert_fault_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(sp_o) && $stable(fp_o));

  assert_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  assert_pc_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> done_o && !fault_o);
endmodule

bind frame_seq frame_seq_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fault_o    (fault_o),
  .pc_load_o  (pc_load_o),
  .fp_o       (fp_o),
  .sp_o       (sp_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ready_i(mem_ready_i)
);

// File: tb/frame_seq_test.sv
module frame_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] pc = '0, tgt = '0;
  logic        busy, done, fault, pc_load;
  logic [31:0] pc_out, fp_out, sp_out;
  logic        req, we, ready;
  logic [31:0] addr, wdata, rdata;

  always #4 clk = ~clk;

  frame_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .pc_i(pc),
    .target_i(tgt), .busy_o(busy), .done_o(done), .fault_o(fault),
    .pc_load_o(pc_load), .pc_o(pc_out), .fp_o(fp_out), .sp_o(sp_out),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_ready_i(ready)
  );

  // memory model with programmable wait length
  logic [31:0] mem [256];
  logic [3:0]  lat = 4'd0;
  logic [3:0]  wcnt = 4'd0;
  int          wr_n = 0, rd_n = 0;
  logic [31:0] wr_a [4];
  logic [31:0] wr_d [4];
  logic [31:0] rd_a [4];

  assign ready = req && (wcnt == lat);
  assign rdata = mem[addr[9:2]];

  always @(posedge clk) begin
    if (req && ready) begin
      wcnt <= 4'd0;
      if (we) begin
        mem[addr[9:2]] <= wdata;
        if (wr_n < 4) begin wr_a[wr_n] <= addr; wr_d[wr_n] <= wdata; end
        wr_n <= wr_n + 1;
      end else begin
        if (rd_n < 4) rd_a[rd_n] <= addr;
        rd_n <= rd_n + 1;
      end
    end else if (req) wcnt <= wcnt + 4'd1;
    else wcnt <= 4'd0;
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // independent model
  logic [31:0] m_sp, m_fp, m_pc;
  logic [31:0] mdl [256];

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] pc;
    logic [31:0] tgt;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 32'h0000_0100, 32'h0000_2000, 4'd0},
    '{2'd1, 32'h0000_2010, 32'h0000_3000, 4'd1},
    '{2'd0, 32'h0000_3020, 32'h0000_4000, 4'd3},
    '{2'd2, 32'h0000_0000, 32'h0000_0000, 4'd2},
    '{2'd2, 32'h0000_0000, 32'h0000_0000, 4'd0},
    '{2'd1, 32'h0000_2400, 32'h0000_5000, 4'd0},
    '{2'd2, 32'h0000_0000, 32'h0000_0000, 4'd1},
    '{2'd2, 32'h0000_0000, 32'h0000_0000, 4'd0}
  };

  task automatic run_op(input vec_t v, input bit poke);
    logic [31:0] e_sp, e_fp, e_pc, ra, o_sp, o_fp;
    bit          e_flt;
    int          n, e_n;
    e_flt = 0; e_sp = m_sp; e_fp = m_fp; e_pc = m_pc; o_sp = m_sp; o_fp = m_fp;
    ra = v.pc + ((v.op == 2'd0) ? 32'd6 : 32'd2);
    if (v.op == 2'd3) e_flt = 1;
    else if (v.op == 2'd2) begin
      if (m_fp[1:0] != 0) e_flt = 1;
      else begin
        e_fp = mdl[m_fp[9:2]]; e_pc = mdl[m_fp[9:2] + 8'd1]; e_sp = m_fp + 32'd12;
      end
    end else begin
      if (m_sp[1:0] != 0) e_flt = 1;
      else begin
        mdl[m_sp[9:2] - 8'd2] = ra; mdl[m_sp[9:2] - 8'd3] = m_fp;
        e_sp = m_sp - 32'd12; e_fp = e_sp; e_pc = v.tgt;
      end
    end
    e_n = e_flt ? 1 : 2 * int'(v.lat) + 3;

    @(negedge clk);
    wr_n = 0; rd_n = 0; lat = v.lat;
    start = 1'b1; op = v.op; pc = v.pc; tgt = v.tgt;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      start = 1'b0;
      if (n == 1) chk("R7 busy after start", {31'd0, busy}, 32'd1);
      if (poke && n == 1) begin start = 1'b1; op = 2'd2; end
      if (n > 100) break;
    end while (!done);
    start = 1'b0;

    chk("R6 cycles to done", n, e_n);
    chk("R8 fault flag", {31'd0, fault}, {31'd0, e_flt});
    chk("R4 pc_load with done", {31'd0, pc_load}, {31'd0, !e_flt});
    chk("R4 sp", sp_out, e_sp);
    chk("R5 fp", fp_out, e_fp);
    if (!e_flt) chk("R5 pc", pc_out, e_pc);
    if (e_flt) begin
      chk("R8 no access", wr_n + rd_n, 0);
      chk("R8 sp kept", sp_out, o_sp);
      chk("R9 fp kept", fp_out, o_fp);
    end else if (v.op == 2'd2) begin
      chk("R5 read count", rd_n, 2);
      chk("R5 read order 1", rd_a[0], o_fp);
      chk("R5 read order 2", rd_a[1], o_fp + 32'd4);
    end else begin
      chk("R2 write count", wr_n, 2);
      chk("R2 ra addr", wr_a[0], o_sp - 32'd8);
      chk(v.op == 2'd0 ? "R2 ra pc+6" : "R3 ra pc+2", wr_d[0], ra);
      chk("R2 fp addr", wr_a[1], o_sp - 32'd12);
      chk("R2 fp data", wr_d[1], o_fp);
    end
    @(negedge clk);
    chk("R7 idle after done", {30'd0, busy, req}, 32'd0);
    chk("R7 done one cycle", {31'd0, done}, 32'd0);
    m_sp = e_sp; m_fp = e_fp; m_pc = e_pc;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; mdl[i] = '0; end
    m_sp = 32'h400; m_fp = 32'h400; m_pc = '0;
    repeat (2) @(negedge clk);
    chk("R1 sp reset", sp_out, 32'h400);
    chk("R1 fp reset", fp_out, 32'h400);
    chk("R1 flags reset", {27'd0, busy, done, fault, pc_load, req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 8; k++) run_op(VEC[k], 1'b0);

    // start while busy ignored
    run_op('{2'd0, 32'h0000_0200, 32'h0000_6000, 4'd2}, 1'b1);
    run_op('{2'd2, 32'h0, 32'h0, 4'd0}, 1'b0);

    // plant misaligned saved frame pointer, then unwind onto it
    run_op('{2'd1, 32'h0000_0300, 32'h0000_7000, 4'd0}, 1'b0);
    mem[m_fp[9:2]] = 32'h0000_03E2;
    mdl[m_fp[9:2]] = 32'h0000_03E2;
    run_op('{2'd2, 32'h0, 32'h0, 4'd1}, 1'b0);
    chk("R5 misaligned fp restored", fp_out, 32'h0000_03E2);
    run_op('{2'd2, 32'h0, 32'h0, 4'd0}, 1'b0);   // R8 fault
    run_op('{2'd3, 32'h0000_0500, 32'h0000_8000, 4'd0}, 1'b0);  // R9 reserved
    run_op('{2'd0, 32'h0000_0600, 32'h0000_9000, 4'd0}, 1'b0);  // call still works

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule